// File: doc/BRIEF.md
# Serial EEPROM Block Reader

This block is an I2C bus master with one fixed job: it copies a block of bytes out of a serial configuration EEPROM, starting at word offset zero. A one-cycle pulse on `start_i` begins a transaction. The controller first performs a dummy write that loads the EEPROM's internal address pointer. It then turns the bus around with a repeated START and clocks the bytes out as a sequential read. Each received byte appears on a plain valid/data port together with its index.

The SCL line is generated from the system clock. Every SCL half-period is `HALF_CLKS` system clocks, divided into two quarter phases. SDA is open-drain: the block asserts `sda_oe_o` to pull the line low and reads the resolved line on `sda_i`.

The master acknowledges every byte it receives except the last. It NACKs the last byte and then releases the bus with a STOP. If the slave fails to acknowledge any of the three address bytes, the transfer is abandoned with a STOP and an error flag. Either way, a one-cycle completion pulse marks the end of the transfer.

Top module: `spd_seq_reader`

## Requirements
- R1: After reset and while idle, `scl_o` is 1, `sda_oe_o` is 0, and `rd_valid_o`, `done_o` and `err_o` are 0.
- R2: A transfer opens with START, which is SDA falling while SCL is high. Byte 8'hA0 (device address 7'h50, write direction bit 0) follows, MSB first. Outside START and STOP, SDA changes only while SCL is low.
- R3: After the slave ACKs 8'hA0, the master sends word address 8'h00 and samples the slave ACK.
- R4: After the word address is ACKed, a repeated START follows with no STOP in between, then byte 8'hA1 (read direction bit 1).
- R5: Exactly 128 bytes are delivered, indices 0 to 127 in order. The first bit received is the MSB. `rd_valid_o` is high for exactly one clock per byte, and `rd_data_o` and `rd_idx_o` are valid in that clock.
- R6: The master pulls SDA low on the ninth clock after bytes 0 to 126. It leaves SDA released on the ninth clock after byte 127, then issues exactly one STOP (SDA rising while SCL is high).
- R7: Each SCL high time and each SCL low time during a transfer lasts `HALF_CLKS` system clocks. SDA is sampled one quarter phase after SCL rises.
- R8: If any of the three address-phase ACK slots reads SDA high, the master issues STOP, sets `err_o` and delivers no bytes.
- R9: `done_o` pulses for exactly one clock after the STOP completes. At that point SCL and SDA are both released. `err_o` holds its value until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a transfer; ignored while busy |
| scl_o | output | 1 | Serial clock level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Resolved SDA line level |
| rd_valid_o | output | 1 | One-cycle strobe per received byte |
| rd_data_o | output | 8 | Received byte |
| rd_idx_o | output | $clog2(N_BYTES) | Index of the received byte |
| done_o | output | 1 | One-cycle pulse when the transfer has ended |
| err_o | output | 1 | Address-phase NACK seen in the last transfer |

## Verification
The SDA stability assertion assumes that `sda_i` reflects only what the master and one well-behaved slave drive, and that the slave changes SDA only after SCL falls. The bench slave model therefore reacts solely to SCL falling edges when it drives data or ACK, and it never stretches the clock. The assertions also assume that `start_i` is used only while the block is idle or that it is harmlessly ignored. The bench pulses it only after the previous completion pulse.

// File: rtl/spd_seq_pkg.sv
package spd_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_TX,
        ST_RX,
        ST_STOP
    } seq_state_e;

    // Byte sent in each write frame: device address (write), word offset,
    // device address (read).
    function automatic logic [7:0] frame_byte(input logic [1:0] fr,
                                              input logic [6:0] dev,
                                              input logic [7:0] offs);
        logic [7:0] b;
        case (fr)
            2'd0:    b = {dev, 1'b0};
            2'd1:    b = offs;
            default: b = {dev, 1'b1};
        endcase
        return b;
    endfunction

endpackage

// File: rtl/spd_qtr_tick.sv
module spd_qtr_tick #(
    parameter int QTR_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (QTR_CLKS > 1) ? $clog2(QTR_CLKS) : 1;

    generate
        if (QTR_CLKS == 1) begin : g_every
            assign tick_o = run_i;
        end else begin : g_count
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (!run_i)
                    cnt_d = '0;
                else if (cnt_q == CW'(QTR_CLKS - 1))
                    cnt_d = '0;
                else
                    cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick_o = run_i && (cnt_q == CW'(QTR_CLKS - 1));

            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o); // R7
        end
    endgenerate

endmodule

// File: rtl/spd_rx_shift.sv
module spd_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (shift_i) sh_d = {sh_q[W-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign word_o = sh_q;

endmodule

// File: rtl/spd_seq_reader.sv
module spd_seq_reader
    import spd_seq_pkg::*;
#(
    parameter int         HALF_CLKS   = 4,
    parameter int         N_BYTES     = 128,
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter logic [7:0] WORD_OFFSET = 8'h00,
    localparam int        IDXW        = $clog2(N_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    output logic            scl_o,
    output logic            sda_oe_o,
    input  logic            sda_i,
    output logic            rd_valid_o,
    output logic [7:0]      rd_data_o,
    output logic [IDXW-1:0] rd_idx_o,
    output logic            done_o,
    output logic            err_o
);
    localparam int            QTR  = HALF_CLKS / 2;
    localparam logic [IDXW-1:0] LAST = IDXW'(N_BYTES - 1);

    typedef struct packed {
        seq_state_e      st;
        logic [1:0]      ph;
        logic [3:0]      bitn;
        logic [1:0]      frame;
        logic [IDXW-1:0] idx;
        logic            nak;
        logic            valid;
        logic            done;
        logic            err;
        logic            scl;
        logic            oe;
    } ctl_t;

    ctl_t n, q;
    logic tick, shift_en;
    logic [7:0] tx_sh;

    spd_qtr_tick #(.QTR_CLKS(QTR)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (q.st != ST_IDLE),
        .tick_o (tick)
    );

    spd_rx_shift #(.W(8)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (shift_en),
        .bit_i   (sda_i),
        .word_o  (rd_data_o)
    );

    always_comb begin
        n        = q;
        n.valid  = 1'b0;
        n.done   = 1'b0;
        shift_en = 1'b0;

        if (q.st == ST_IDLE) begin
            if (start_i) begin
                n.st    = ST_START;
                n.ph    = 2'd0;
                n.bitn  = 4'd0;
                n.frame = 2'd0;
                n.idx   = '0;
                n.err   = 1'b0;
            end
        end else if (tick) begin
            n.ph = q.ph + 2'd1;
            case (q.st)
                ST_START: if (q.ph == 2'd3) begin
                    n.st   = ST_TX;
                    n.bitn = 4'd0;
                end
                ST_TX: begin
                    if (q.ph == 2'd2 && q.bitn == 4'd8) n.nak = sda_i;
                    if (q.ph == 2'd3) begin
                        if (q.bitn != 4'd8) begin
                            n.bitn = q.bitn + 4'd1;
                        end else begin
                            n.bitn = 4'd0;
                            if (q.nak) begin
                                n.st  = ST_STOP;
                                n.err = 1'b1;
                            end else if (q.frame == 2'd0) begin
                                n.frame = 2'd1;
                            end else if (q.frame == 2'd1) begin
                                n.frame = 2'd2;
                                n.st    = ST_START;
                            end else begin
                                n.st = ST_RX;
                            end
                        end
                    end
                end
                ST_RX: begin
                    if (q.ph == 2'd2 && q.bitn != 4'd8) begin
                        shift_en = 1'b1;
                        if (q.bitn == 4'd7) n.valid = 1'b1;
                    end
                    if (q.ph == 2'd3) begin
                        if (q.bitn != 4'd8) begin
                            n.bitn = q.bitn + 4'd1;
                        end else begin
                            n.bitn = 4'd0;
                            if (q.idx == LAST) n.st = ST_STOP;
                            else               n.idx = q.idx + 1'b1;
                        end
                    end
                end
                ST_STOP: if (q.ph == 2'd3) begin
                    n.st   = ST_IDLE;
                    n.done = 1'b1;
                end
                default: n.st = ST_IDLE;
            endcase
        end

        // Line levels for the state being entered; phase 0 holds SDA.
        tx_sh = frame_byte(n.frame, DEV_ADDR, WORD_OFFSET) << n.bitn;
        case (n.st)
            ST_START: begin
                n.scl = (n.frame == 2'd0) || n.ph[1];
                if (n.ph == 2'd3)      n.oe = 1'b1;
                else if (n.ph != 2'd0) n.oe = 1'b0;
            end
            ST_TX: begin
                n.scl = n.ph[1];
                if (n.ph != 2'd0) n.oe = (n.bitn != 4'd8) && !tx_sh[7];
            end
            ST_RX: begin
                n.scl = n.ph[1];
                if (n.ph != 2'd0) n.oe = (n.bitn == 4'd8) && (n.idx != LAST);
            end
            ST_STOP: begin
                n.scl = n.ph[1];
                if (n.ph == 2'd1 || n.ph == 2'd2) n.oe = 1'b1;
                else if (n.ph == 2'd3)            n.oe = 1'b0;
            end
            default: begin
                n.scl = 1'b1;
                n.oe  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.scl   <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign scl_o      = q.scl;
    assign sda_oe_o   = q.oe;
    assign rd_valid_o = q.valid;
    assign rd_idx_o   = q.idx;
    assign done_o     = q.done;
    assign err_o      = q.err;

    AST_IDLE_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> (scl_o && !sda_oe_o)); // R1
    AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_TX || q.st == ST_RX) && scl_o && $past(scl_o)) |-> $stable(sda_oe_o)); // R2
    AST_VALID_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (q.st == ST_RX)); // R5
    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !rd_valid_o); // R8
    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (scl_o && !sda_oe_o && q.st == ST_IDLE)); // R9

endmodule

// File: tb/spd_seq_reader_bench.sv
module spd_seq_reader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int NB         = 128;
    localparam int IW         = $clog2(NB);

    typedef struct packed {
        logic [1:0] nack_at;
        logic       exp_err;
        logic [8:0] exp_n;
    } vec_t;

    localparam vec_t VEC [0:4] = '{
        '{2'd0, 1'b0, 9'd128},
        '{2'd1, 1'b1, 9'd0},
        '{2'd2, 1'b1, 9'd0},
        '{2'd3, 1'b1, 9'd0},
        '{2'd0, 1'b0, 9'd128}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic scl, m_oe, rd_valid, done, err;
    logic [7:0] rd_data;
    logic [IW-1:0] rd_idx;
    logic s_oe = 1'b0;
    wire  sda_line = !(m_oe || s_oe);

    int checks = 0, failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spd_seq_reader #(.HALF_CLKS(HALF), .N_BYTES(NB)) u_spd_seq_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .scl_o      (scl),
        .sda_oe_o   (m_oe),
        .sda_i      (sda_line),
        .rd_valid_o (rd_valid),
        .rd_data_o  (rd_data),
        .rd_idx_o   (rd_idx),
        .done_o     (done),
        .err_o      (err)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 29 + 60) ^ (i >> 3));
    endfunction

    // ---------------- behavioural EEPROM slave ----------------
    int nack_at = 0;
    int bpos = -1, fno = 0, mode = 0;
    int n_start = 0, n_stop = 0, rd_stops = -1, n_ack = 0, n_nak = 0;
    logic [7:0] shreg = 8'h00, ptr = 8'h00, v;
    logic [7:0] cap [1:3];
    logic mack = 1'b0, rd_pend = 1'b0;
    logic scl_p = 1'b1, sda_p = 1'b1;

    always @(scl or sda_line) begin
        if (scl !== scl_p) begin
            scl_p = scl;
            sda_p = sda_line;
            if (scl) begin
                if (mode == 1 && bpos >= 0 && bpos < 8) shreg = {shreg[6:0], sda_line};
                if (mode == 2 && bpos == 8) begin
                    mack = sda_line;
                    if (mack) n_nak++; else n_ack++;
                end
            end else if (mode != 0) begin
                bpos = (bpos == 8) ? 0 : bpos + 1;
                if (mode == 1) begin
                    if (bpos == 8) begin
                        fno++;
                        if (fno <= 3) cap[fno] = shreg;
                        if (fno == nack_at) s_oe = 1'b0;
                        else begin
                            s_oe = 1'b1;
                            if (fno == 2) ptr = shreg;
                            if (shreg == 8'hA1) begin
                                rd_pend  = 1'b1;
                                rd_stops = n_stop;
                            end
                        end
                    end else begin
                        s_oe = 1'b0;
                        if (bpos == 0 && rd_pend) begin
                            mode = 2;
                            rd_pend = 1'b0;
                            v = pat(int'(ptr));
                            s_oe = !v[7];
                        end
                    end
                end else begin
                    if (bpos == 8) s_oe = 1'b0;
                    else if (bpos == 0) begin
                        if (mack) begin
                            mode = 0;
                            s_oe = 1'b0;
                        end else begin
                            ptr = ptr + 8'd1;
                            v = pat(int'(ptr));
                            s_oe = !v[7];
                        end
                    end else begin
                        v = pat(int'(ptr));
                        s_oe = !v[7-bpos];
                    end
                end
            end
        end else if (sda_line !== sda_p) begin
            sda_p = sda_line;
            if (scl) begin
                if (!sda_line) begin
                    n_start++;
                    bpos = -1;
                    mode = 1;
                    rd_pend = 1'b0;
                    s_oe = 1'b0;
                end else begin
                    n_stop++;
                    mode = 0;
                    s_oe = 1'b0;
                end
            end
        end
    end

    // ---------------- output monitor ----------------
    int n_bytes = 0, bad_bytes = 0, exp_idx = 0, n_done = 0;
    int hi_run = 0, lo_run = 0, hi_min = 1 << 20, hi_max = 0, lo_min = 1 << 20, lo_max = 0;
    logic in_hi = 1'b0, in_lo = 1'b0, scl_m = 1'b1, err_at_done = 1'b0;

    always @(negedge clk) begin
        if (rd_valid) begin
            n_bytes++;
            if (rd_data !== pat(int'(rd_idx)) || int'(rd_idx) != exp_idx) bad_bytes++;
            exp_idx++;
        end
        if (done) begin
            n_done++;
            err_at_done = err;
            in_hi = 1'b0;
        end
        if (scl && !scl_m) begin
            if (in_lo) begin
                if (lo_run < lo_min) lo_min = lo_run;
                if (lo_run > lo_max) lo_max = lo_run;
            end
            in_hi = 1'b1; hi_run = 1;
        end else if (!scl && scl_m) begin
            if (in_hi) begin
                if (hi_run < hi_min) hi_min = hi_run;
                if (hi_run > hi_max) hi_max = hi_run;
            end
            in_hi = 1'b0; in_lo = 1'b1; lo_run = 1;
        end else if (scl) hi_run++;
        else lo_run++;
        if (done) in_lo = 1'b0;
        scl_m = scl;
    end

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_txn(input int nk);
        nack_at = nk;
        fno = 0; n_start = 0; n_stop = 0; rd_stops = -1; n_ack = 0; n_nak = 0;
        n_bytes = 0; bad_bytes = 0; exp_idx = 0; n_done = 0;
        cap[1] = 8'hFF; cap[2] = 8'hFF; cap[3] = 8'hFF;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int t = 0; t < 30000 && n_done == 0; t++) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_eq("R1 scl", int'(scl), 1);
        check_eq("R1 sda_oe", int'(m_oe), 0);
        check_eq("R1 valid", int'(rd_valid), 0);
        check_eq("R1 done/err", int'(done) + int'(err), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_eq("R1 idle after reset", int'(scl) * 2 + int'(m_oe), 2);

        for (int r = 0; r < 5; r++) begin
            run_txn(int'(VEC[r].nack_at));
            check_eq("R9 single done pulse", n_done, 1);
            check_eq("R8 error flag", int'(err_at_done), int'(VEC[r].exp_err));
            check_eq("R5 byte count", n_bytes, int'(VEC[r].exp_n));
            check_eq("R6 stop count", n_stop, 1);
            if (VEC[r].nack_at == 2'd0) begin
                check_eq("R5 data/index mismatches", bad_bytes, 0);
                check_eq("R2 device write byte", int'(cap[1]), 8'hA0);
                check_eq("R3 word address", int'(cap[2]), 8'h00);
                check_eq("R4 device read byte", int'(cap[3]), 8'hA1);
                check_eq("R4 starts", n_start, 2);
                check_eq("R4 stops before read", rd_stops, 0);
                check_eq("R6 master acks", n_ack, NB - 1);
                check_eq("R6 master nacks", n_nak, 1);
            end else begin
                check_eq("R8 starts before abort", n_start,
                         (VEC[r].nack_at == 2'd3) ? 2 : 1);
            end
            check_eq("R9 bus released", int'(scl) * 2 + int'(m_oe), 2);
        end

        // R9: error cleared by the next start (last row was clean after a nack row)
        check_eq("R9 err cleared", int'(err), 0);
        // R7: SCL half periods
        check_eq("R7 min high", hi_min, HALF);
        check_eq("R7 max high", hi_max, HALF);
        check_eq("R7 min low", lo_min, HALF);
        check_eq("R7 max low", lo_max, HALF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule